// File: doc/BRIEF.md
# Zero-Overhead Trace Issue Unit

This unit sits between instruction fetch and the main pipeline of a small in-order core. Each cycle it can take an aligned pair of consecutive 32-bit instruction words. It decodes both words at once and sorts them. Ordinary words go into a compacting issue buffer that feeds the main pipeline one instruction per cycle. Trace words never enter that buffer. Each trace word is placed in a side queue, tagged with the ordinary instruction that comes before it in program order. Because a trace word takes no issue slot, the pipeline sees the same instruction sequence with the same cycle timing as the program without traces. This holds as long as fetch runs ahead of issue, which the two-words-per-cycle fetch allows.

A trace entry is released on the trace port in the cycle its predecessor retires. Release carries a one-cycle strobe, the 12-bit identifier and the predecessor's PC. Several entries that are ready together drain one per cycle, in program order. A flush from the retire stage works as follows:
- It empties the issue buffer.
- It blocks fetch for that cycle.
- It drops every trace entry whose predecessor has not retired.

Trace words fetched after reset or after a flush have no pending predecessor and are released at once.

Both the fetch side and the issue side are valid/ready streams:
- A pair moves when `fetch_valid` and `fetch_ready` are both high.
- An instruction moves when `iss_valid` and `iss_ready` are both high.
- While `iss_valid` is high and `iss_ready` is low, the issued PC and word hold still.
- `fetch_ready` may depend on `iss_ready` in the same cycle.

The trace port has no ready. Stalling it would change program timing, so the queue depth is sized for the worst number of traces in flight. Queue and buffer depths must be powers of two.

Top module: `trace_issue_unit`

## Requirements
- R1: During and right after synchronous reset, `iss_valid` and `trace_valid` are low and `fetch_ready` is high.
- R2: A word is a trace word exactly when bits [6:0] are 7'b0001011 and bits [14:12] are 3'b000; its identifier is bits [31:20]. Words with opcode 7'b0001011 and any other value in bits [14:12] are ordinary.
- R3: Only ordinary words are issued, in program order, each with its own address (pair PC for word 0, pair PC + 4 for word 1).
- R4: Retire times of the ordinary instructions are identical whether or not trace words are interleaved in the program, given the same issue-ready pattern and a fetch that keeps the buffer fed.
- R5: A trace entry is strobed in the same cycle its predecessor's retire pulse is high, carrying its identifier and the predecessor's PC.
- R6: At most one trace is strobed per cycle; entries ready together, such as two trace words of one pair, come out on consecutive cycles in program order.
- R7: In a flush cycle `iss_valid` and `fetch_ready` are low; the next cycle `iss_valid` is low. Trace entries whose predecessor has not retired by that cycle are never strobed.
- R8: A pair is accepted only when both the issue buffer and the trace queue can take two more entries (counting the same-cycle pop); a stalled issue output holds its PC and word.
- R9: A trace word with no predecessor since reset or flush is strobed in the cycle after its pair is accepted (if the queue ahead is empty), with PC 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetched pair present |
| fetch_ready | output | 1 | Pair can be taken this cycle |
| fetch_pc | input | PC_W | Address of word 0 of the pair (8-byte aligned) |
| fetch_word0 | input | 32 | Lower-address word |
| fetch_word1 | input | 32 | Higher-address word |
| iss_valid | output | 1 | Ordinary instruction offered to the pipeline |
| iss_ready | input | 1 | Pipeline advances |
| iss_pc | output | PC_W | Address of the offered instruction |
| iss_instr | output | 32 | Offered instruction word |
| retire | input | 1 | Oldest in-flight ordinary instruction retires |
| flush | input | 1 | Retire-stage redirect; younger work is discarded |
| trace_valid | output | 1 | One-cycle trace strobe |
| trace_id | output | 12 | Identifier of the strobed trace |
| trace_pc | output | PC_W | PC of the trace's predecessor (0 if none) |

## Verification
One ordinary program is run twice, once plain and once with trace words inserted. The inserted traces take several forms: single traces, a trace before an ordinary word in the same pair, and a pair made only of traces. Matching retire times across the two runs separate true zero-cost issue from designs that spend a slot on each trace. A third run uses random issue back-pressure and a flush at a chosen retire, with the redirect target starting on a trace word. This run tells apart correct dropping of pending traces, correct immediate release of traces with no predecessor, and correct holding of stalled output. Opcode 7'b0001011 words with a nonzero minor field are mixed into the program. They show whether decode keys on the full trace encoding.

// File: rtl/trace_issue_pkg.sv
package trace_issue_pkg;

  typedef logic [31:0] iword_t;

  localparam logic [6:0] TRACE_OPC   = 7'b0001011;
  localparam logic [2:0] TRACE_MINOR = 3'b000;
  localparam int         TID_W       = 12;

  function automatic logic is_trace_word(iword_t w);
    return (w[6:0] == TRACE_OPC) && (w[14:12] == TRACE_MINOR);
  endfunction

  function automatic logic [TID_W-1:0] trace_id_of(iword_t w);
    return w[31:20];
  endfunction

endpackage

// File: rtl/tiu_pair_decode.sv
module tiu_pair_decode
  import trace_issue_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SEQ_W = 8,
  localparam int OE_W = PC_W + 32,
  localparam int TE_W = SEQ_W + PC_W + TID_W
) (
  input  logic [PC_W-1:0]       pair_pc,
  input  iword_t [1:0]          words,
  input  logic [SEQ_W-1:0]      seq_base,
  input  logic [PC_W-1:0]       prev_pc,
  output logic [1:0]            ord_n,
  output logic [1:0][OE_W-1:0]  ord_ent,
  output logic [1:0]            trc_n,
  output logic [1:0][TE_W-1:0]  trc_ent,
  output logic [SEQ_W-1:0]      seq_next,
  output logic [PC_W-1:0]       prev_pc_next
);

  logic [1:0]            is_t;
  logic [1:0][PC_W-1:0]  slot_pc;
  logic [1:0][TE_W-1:0]  slot_te;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    assign is_t[g]    = is_trace_word(words[g]);
    assign slot_pc[g] = pair_pc + PC_W'(4 * g);
  end

  // Predecessor of a trace word: last ordinary word before it in program order.
  assign slot_te[0] = {seq_base - SEQ_W'(1), prev_pc, trace_id_of(words[0])};
  assign slot_te[1] = is_t[0] ? {seq_base - SEQ_W'(1), prev_pc, trace_id_of(words[1])}
                              : {seq_base, slot_pc[0], trace_id_of(words[1])};

  always_comb begin
    ord_n   = 2'd0;
    trc_n   = 2'd0;
    ord_ent = '0;
    trc_ent = '0;
    for (int s = 0; s < 2; s++) begin
      if (is_t[s]) begin
        trc_ent[trc_n[0]] = slot_te[s];
        trc_n             = trc_n + 2'd1;
      end else begin
        ord_ent[ord_n[0]] = {slot_pc[s], words[s]};
        ord_n             = ord_n + 2'd1;
      end
    end
  end

  assign seq_next     = seq_base + SEQ_W'(ord_n);
  assign prev_pc_next = !is_t[1] ? slot_pc[1] : (!is_t[0] ? slot_pc[0] : prev_pc);

endmodule

// File: rtl/tiu_issue_fifo.sv
module tiu_issue_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [1:0]        push_n,
  input  logic [1:0][W-1:0] push_d,
  input  logic              pop,
  output logic              empty,
  output logic [W-1:0]      head,
  output logic              room2,
  output logic [CW-1:0]     count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr, wptr;

  assign empty = (count == '0);
  assign head  = mem[rptr];
  assign room2 = (32'(count) + 32'd2) <= (32'(DEPTH) + {31'b0, pop});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + AW'(push_n);
      rptr  <= rptr + AW'(pop);
      count <= count + CW'(push_n) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!clear && push_n != 2'd0) mem[wptr] <= push_d[0];
    if (!clear && push_n == 2'd2) mem[wptr + AW'(1)] <= push_d[1];
  end

endmodule

// File: rtl/tiu_trace_queue.sv
module tiu_trace_queue
  import trace_issue_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SEQ_W = 8,
  parameter int DEPTH = 8,
  localparam int TE_W = SEQ_W + PC_W + TID_W,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic [1:0]           push_n,
  input  logic [1:0][TE_W-1:0] push_ent,
  input  logic [SEQ_W-1:0]     ret_eff,
  output logic                 emit,
  output logic [TID_W-1:0]     emit_id,
  output logic [PC_W-1:0]      emit_pc,
  output logic                 room2,
  output logic [CW-1:0]        count
);

  logic [TE_W-1:0]  mem [DEPTH];
  logic [AW-1:0]    rptr, wptr;
  logic [DEPTH-1:0] slot_rdy;
  logic [CW-1:0]    nready;

  // An entry is ready once retirements have passed its predecessor tag.
  for (genvar i = 0; i < DEPTH; i++) begin : g_rdy
    logic [SEQ_W-1:0] diff;
    assign diff        = ret_eff - mem[i][TE_W-1 -: SEQ_W] - SEQ_W'(1);
    assign slot_rdy[i] = !diff[SEQ_W-1];
  end

  // Ready entries form a prefix of the queue; count them for flush compaction.
  always_comb begin
    nready = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < count) && slot_rdy[rptr + AW'(i)]) nready = nready + CW'(1);
    end
  end

  assign emit    = (count != '0) && slot_rdy[rptr];
  assign emit_id = mem[rptr][TID_W-1:0];
  assign emit_pc = mem[rptr][TID_W +: PC_W];
  assign room2   = (32'(count) + 32'd2) <= (32'(DEPTH) + {31'b0, emit});

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (flush) begin
      rptr  <= rptr + AW'(emit);
      wptr  <= rptr + AW'(nready);
      count <= nready - CW'(emit);
    end else begin
      rptr  <= rptr + AW'(emit);
      wptr  <= wptr + AW'(push_n);
      count <= count + CW'(push_n) - CW'(emit);
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && push_n != 2'd0) mem[wptr] <= push_ent[0];
    if (!flush && push_n == 2'd2) mem[wptr + AW'(1)] <= push_ent[1];
  end

endmodule

// File: rtl/trace_issue_unit.sv
module trace_issue_unit
  import trace_issue_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int IQ_DEPTH = 8,
  parameter int TQ_DEPTH = 8,
  parameter int SEQ_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic [31:0]       fetch_word0,
  input  logic [31:0]       fetch_word1,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [PC_W-1:0]   iss_pc,
  output logic [31:0]       iss_instr,
  input  logic              retire,
  input  logic              flush,
  output logic              trace_valid,
  output logic [TID_W-1:0]  trace_id,
  output logic [PC_W-1:0]   trace_pc
);

  localparam int OE_W  = PC_W + 32;
  localparam int TE_W  = SEQ_W + PC_W + TID_W;
  localparam int IQ_CW = $clog2(IQ_DEPTH + 1);
  localparam int TQ_CW = $clog2(TQ_DEPTH + 1);

  logic [SEQ_W-1:0] enq_seq, ret_seq, ret_eff, seq_next;
  logic [PC_W-1:0]  last_pc, last_pc_next;

  logic [1:0]            ord_n, trc_n;
  logic [1:0][OE_W-1:0]  ord_ent;
  logic [1:0][TE_W-1:0]  trc_ent;

  logic             accept, iq_empty, iq_room2, tq_room2, iss_fire;
  logic [OE_W-1:0]  iq_head;
  logic [IQ_CW-1:0] iq_count;
  logic [TQ_CW-1:0] tq_count;

  assign ret_eff     = ret_seq + SEQ_W'(retire);
  assign fetch_ready = !flush && iq_room2 && tq_room2;
  assign accept      = fetch_valid && fetch_ready;
  assign iss_valid   = !iq_empty && !flush;
  assign iss_fire    = iss_valid && iss_ready;
  assign iss_pc      = iq_head[OE_W-1 -: PC_W];
  assign iss_instr   = iq_head[31:0];

  tiu_pair_decode #(.PC_W(PC_W), .SEQ_W(SEQ_W)) u_dec (
    .pair_pc      (fetch_pc),
    .words        ({fetch_word1, fetch_word0}),
    .seq_base     (enq_seq),
    .prev_pc      (last_pc),
    .ord_n        (ord_n),
    .ord_ent      (ord_ent),
    .trc_n        (trc_n),
    .trc_ent      (trc_ent),
    .seq_next     (seq_next),
    .prev_pc_next (last_pc_next)
  );

  tiu_issue_fifo #(.W(OE_W), .DEPTH(IQ_DEPTH)) u_iq (
    .clk    (clk),
    .rst    (rst),
    .clear  (flush),
    .push_n (accept ? ord_n : 2'd0),
    .push_d (ord_ent),
    .pop    (iss_fire),
    .empty  (iq_empty),
    .head   (iq_head),
    .room2  (iq_room2),
    .count  (iq_count)
  );

  tiu_trace_queue #(.PC_W(PC_W), .SEQ_W(SEQ_W), .DEPTH(TQ_DEPTH)) u_tq (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .push_n   (accept ? trc_n : 2'd0),
    .push_ent (trc_ent),
    .ret_eff  (ret_eff),
    .emit     (trace_valid),
    .emit_id  (trace_id),
    .emit_pc  (trace_pc),
    .room2    (tq_room2),
    .count    (tq_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enq_seq <= '0;
      ret_seq <= '0;
      last_pc <= '0;
    end else begin
      ret_seq <= ret_eff;
      if (flush) begin
        enq_seq <= ret_eff;
        last_pc <= '0;
      end else if (accept) begin
        enq_seq <= seq_next;
        last_pc <= last_pc_next;
      end
    end
  end

endmodule

// File: rtl/tiu_checker.sv
module tiu_checker
  import trace_issue_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int IQ_DEPTH = 8,
  parameter int TQ_DEPTH = 8,
  localparam int IQ_CW   = $clog2(IQ_DEPTH + 1),
  localparam int TQ_CW   = $clog2(TQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [PC_W-1:0]  iss_pc,
  input logic [31:0]      iss_instr,
  input logic             flush,
  input logic             trace_valid,
  input logic [IQ_CW-1:0] iq_count,
  input logic [TQ_CW-1:0] tq_count
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!iss_valid && !trace_valid));

  p_no_trace_issued_r3: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !is_trace_word(iss_instr));

  p_flush_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!iss_valid && !fetch_ready));

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !iss_valid);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready && !flush) |=>
      (flush || (iss_valid && $stable(iss_pc) && $stable(iss_instr))));

  p_iq_bound_r8: assert property (@(posedge clk) disable iff (rst)
    32'(iq_count) <= IQ_DEPTH);

  p_tq_bound_r8: assert property (@(posedge clk) disable iff (rst)
    32'(tq_count) <= TQ_DEPTH);

endmodule

bind trace_issue_unit tiu_checker #(
  .PC_W(PC_W), .IQ_DEPTH(IQ_DEPTH), .TQ_DEPTH(TQ_DEPTH)
) u_tiu_checker (
  .clk         (clk),
  .rst         (rst),
  .fetch_ready (fetch_ready),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .iss_pc      (iss_pc),
  .iss_instr   (iss_instr),
  .flush       (flush),
  .trace_valid (trace_valid),
  .iq_count    (iq_count),
  .tq_count    (tq_count)
);

// File: tb/tb_trace_issue_unit.sv
module tb_trace_issue_unit;

  localparam int PC_W = 32;
  localparam int BASE = 32'h100;
  localparam int NORD = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_valid = 1'b0, fetch_ready;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [31:0] fetch_word0 = '0, fetch_word1 = '0;
  logic iss_valid, iss_ready = 1'b0;
  logic [PC_W-1:0] iss_pc;
  logic [31:0] iss_instr;
  logic retire = 1'b0, flush = 1'b0;
  logic trace_valid;
  logic [11:0] trace_id;
  logic [PC_W-1:0] trace_pc;

  trace_issue_unit dut (.*);

  initial forever #10 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [31:0] prog [0:255];
  logic [31:0] ords [0:NORD-1];
  int plen;
  int ret_cyc [0:255];
  int ret_a [0:NORD-1];
  // bench model state
  logic [31:0] mf_w [0:255];
  int mf_pc [0:255], mf_u [0:255], mf_h, mf_t;
  int mt_id [0:255], mt_pc [0:255], mt_pred [0:255], mt_h, mt_t;
  int pipe_v [0:2], pipe_u [0:2];
  int dropped, last_emit_pred, last_emit_id;

  function automatic logic is_tr(logic [31:0] w);
    return w[6:0] == 7'b0001011 && w[14:12] == 3'b000;
  endfunction
  function automatic logic [31:0] mk_trace(int id);
    return {id[11:0], 13'd0, 7'b0001011};
  endfunction
  function automatic logic [31:0] mk_ord(int k, logic [31:0] r);
    if (k % 9 == 4) return {r[31:15], 3'((k % 7) + 1), r[11:7], 7'b0001011};
    return {r[31:7], 7'b0010011};
  endfunction
  function automatic int ready_pat(int c, bit rnd);
    if (c < 10) return 0;
    if (rnd) return ($urandom % 4) != 0 ? 1 : 0;
    return (c % 7) != 3 ? 1 : 0;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; fetch_valid = 1'b0; iss_ready = 1'b0; retire = 1'b0; flush = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  function automatic bit pred_ready(int p);
    if (p < 0) return 1;
    if (ret_cyc[p] >= 0) return 1;
    return retire && pipe_v[2] != 0 && pipe_u[2] == p;
  endfunction

  task automatic run_prog(int flush_uid, int tgt, bit rnd, int ncyc, bit order_chk);
    int fptr = 0, next_uid = 0, last_uid = -1, last_pc = 0;
    for (int i = 0; i < 256; i++) ret_cyc[i] = -1;
    mf_h = 0; mf_t = 0; mt_h = 0; mt_t = 0; dropped = 0;
    last_emit_pred = -2; last_emit_id = 0;
    for (int i = 0; i < 3; i++) begin pipe_v[i] = 0; pipe_u[i] = 0; end
    do_reset();
    cyc = 0;
    for (int n = 0; n < ncyc; n++) begin
      bit exp_iv, exp_tv, stalled;
      stalled = iss_valid && !iss_ready;
      if (n > 0) @(negedge clk);
      retire = pipe_v[2] != 0;
      flush = retire && pipe_u[2] == flush_uid;
      fetch_valid = fptr < plen;
      fetch_pc = PC_W'(BASE + fptr * 4);
      fetch_word0 = prog[fptr];
      fetch_word1 = prog[fptr + 1];
      iss_ready = ready_pat(cyc, rnd) != 0;
      #1;
      if (n == 0) begin
        check(!iss_valid && !trace_valid, "R1", "outputs idle after reset", {iss_valid, trace_valid}, 0);
        check(fetch_ready, "R1", "fetch_ready after reset", fetch_ready, 1);
      end
      exp_iv = (mf_h != mf_t) && !flush;
      check(iss_valid == exp_iv, stalled ? "R8" : "R3", "iss_valid", iss_valid, exp_iv);
      if (iss_valid && exp_iv) begin
        string rq;
        rq = stalled ? "R8" : (mf_w[mf_h][6:0] == 7'b0001011 ? "R2" : "R3");
        check(iss_instr == mf_w[mf_h], rq, "iss_instr", iss_instr, mf_w[mf_h]);
        check(int'(iss_pc) == mf_pc[mf_h], rq, "iss_pc", iss_pc, mf_pc[mf_h]);
      end
      if (flush) check(!fetch_ready, "R7", "fetch_ready in flush", fetch_ready, 0);
      exp_tv = (mt_h != mt_t) && pred_ready(mt_pred[mt_h]);
      begin
        string rq;
        rq = (mt_h != mt_t && mt_pred[mt_h] < 0) ? "R9" :
             ((mt_h != mt_t && mt_pred[mt_h] == last_emit_pred) ? "R6" : "R5");
        check(trace_valid == exp_tv, rq, "trace_valid", trace_valid, exp_tv);
        if (trace_valid && exp_tv) begin
          check(trace_id == 12'(mt_id[mt_h]), rq, "trace_id", trace_id, mt_id[mt_h]);
          check(int'(trace_pc) == mt_pc[mt_h], rq, "trace_pc", trace_pc, mt_pc[mt_h]);
          if (order_chk)
            check(int'(trace_id) > last_emit_id, "R6", "trace order", trace_id, last_emit_id + 1);
          last_emit_id = int'(trace_id);
        end
      end
      // advance bench model to the coming clock edge
      if (retire) ret_cyc[pipe_u[2]] = cyc;
      if (exp_tv) begin last_emit_pred = mt_pred[mt_h]; mt_h++; end
      pipe_v[2] = pipe_v[1]; pipe_u[2] = pipe_u[1];
      pipe_v[1] = pipe_v[0]; pipe_u[1] = pipe_u[0];
      pipe_v[0] = 0;
      if (exp_iv && iss_ready) begin pipe_v[0] = 1; pipe_u[0] = mf_u[mf_h]; mf_h++; end
      if (flush) begin
        for (int i = 0; i < 3; i++) pipe_v[i] = 0;
        mf_h = mf_t;
        while (mt_h != mt_t && pred_ready(mt_pred[mt_h]) && mt_h != mt_t) begin
          if (mt_h + 1 == mt_t) break;
          break;
        end
        begin
          int keep;
          keep = mt_h;
          while (keep != mt_t && pred_ready(mt_pred[keep])) keep++;
          dropped += mt_t - keep;
          mt_t = keep;
        end
        fptr = tgt; last_uid = -1; last_pc = 0;
      end else if (fetch_valid && fetch_ready) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] w;
          w = prog[fptr + s];
          if (is_tr(w)) begin
            mt_id[mt_t] = int'(w[31:20]); mt_pc[mt_t] = last_pc; mt_pred[mt_t] = last_uid; mt_t++;
          end else begin
            mf_w[mf_t] = w; mf_pc[mf_t] = BASE + (fptr + s) * 4; mf_u[mf_t] = next_uid; mf_t++;
            last_uid = next_uid; last_pc = BASE + (fptr + s) * 4; next_uid++;
          end
        end
        fptr += 2;
      end
      cyc++;
    end
    check(mt_h == mt_t, "R5", "all expected traces strobed", mt_t - mt_h, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog expired: actual %0d expected <20000 cycles", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int tid;
    void'($urandom(32'd4242));
    for (int k = 0; k < NORD; k++) ords[k] = mk_ord(k, $urandom);

    // Run A: plain program
    plen = NORD;
    for (int k = 0; k < NORD; k++) prog[k] = ords[k];
    prog[NORD] = 32'h13; prog[NORD + 1] = 32'h13;
    run_prog(-1, 0, 0, 150, 1);
    for (int k = 0; k < NORD; k++) ret_a[k] = ret_cyc[k];

    // Run B: same ordinaries with traces interleaved
    plen = 0; tid = 1;
    for (int k = 0; k < NORD; k++) begin
      int nt;
      prog[plen++] = ords[k];
      if (k == 5) nt = (plen % 2 == 0) ? 2 : 3;        // an all-trace pair
      else if (k == 10) nt = (plen % 2 == 0) ? 1 : 2;  // trace then ordinary in one pair
      else begin
        int r;
        r = int'($urandom % 16);
        nt = (r < 3) ? 1 : ((r == 3) ? 2 : 0);
      end
      for (int t = 0; t < nt; t++) prog[plen++] = mk_trace(tid++);
    end
    if (plen % 2 != 0) prog[plen++] = mk_trace(tid++);
    prog[plen] = 32'h13; prog[plen + 1] = 32'h13;
    run_prog(-1, 0, 0, 150, 1);
    for (int k = 0; k < NORD; k++)
      check(ret_cyc[k] == ret_a[k] && ret_a[k] >= 0, "R4", "retire cycle vs plain run", ret_cyc[k], ret_a[k]);

    // Run C: flush at a chosen retire, redirect onto a trace word, random back-pressure
    prog[40] = mk_trace(12'hABC);
    run_prog(6, 40, 1, 200, 0);
    check(dropped > 0, "R7", "pending traces dropped by flush", dropped, 1);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule